// File: doc/BRIEF.md
# Reloading Baud and Clock-Out Timer

This block is a 16-bit up-counter paired with a software-loaded 16-bit reload register. It serves two uses that can run together. The first is a serial-port bit-rate source: every counter rollover advances a divide-by-16 stage, and each wrap of that stage produces one tick. The tick is routed to a transmit output and to a receive output, and each route has its own select bit. The second use is a programmable clock pin. The pin inverts on every rollover, which gives a 50% duty-cycle square wave. Both uses take their rate from the same reload value.

While the run bit is clear, the counter is held at the reload value and both prescalers are held at zero. Once started, the counter advances once per state time, which is every two oscillator clocks. When it rolls over from all-ones it reloads from the reload register. A rollover never raises an overflow flag in this block. The bit-rate tick therefore arrives every 32 × (65536 − reload) clocks, and the clock pin has a period of 4 × (65536 − reload) clocks.

A separate external pin is synchronised and watched for falling edges. When the external-enable bit is set, a falling edge sets a sticky external flag, which software clears. The edge causes no reload and leaves the counter untouched.

All pins are plain control and status signals. A configuration write or a reload write takes effect on the clock edge where its write strobe is high. There is no data stream and no back-pressure.

Top module: `baud_clkout_timer`

## Requirements
- R1: Out of reset, tx_tick, rx_tick, clk_out and ext_flag are all 0.
- R2: With cfg_oe=1, cfg_csel=0 and cfg_run=1, clk_out first changes level 2×N clock edges after the edge that starts the run, where N = 65536 − reload. It then changes every 2×N edges, so high and low times are equal.
- R3: While cfg_oe=0 or cfg_csel=1, clk_out is held at 0.
- R4: With cfg_tclk=1, tx_tick is a one-cycle pulse, first seen 32×N edges after the start edge and then every 32×N edges.
- R5: tx_tick pulses only while cfg_tclk=1, and rx_tick pulses only while cfg_rclk=1. The two selects act independently, and both outputs share the same timing.
- R6: Clearing cfg_run freezes clk_out at its level and stops all ticks. It also resets the divide-by-16 stage and the counter, so after a restart the first tick again comes a full 32×N edges after the start edge.
- R7: With cfg_exen=1, a falling edge on ext_pin sets ext_flag on the third clock edge after the change. The flag then stays set until a flag_clr pulse clears it, and a new edge in the same cycle as flag_clr wins over the clear.
- R8: A rising edge on ext_pin, or any edge while cfg_exen=0, leaves ext_flag at 0. A falling edge never reloads the counter or shifts the clk_out or tick timing.
- R9: With both tick selects at 0 and the clock pin disabled, the counter does not run, and no output pulses or toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Loads all six control bits below on this edge |
| cfg_run | input | 1 | Run bit: 1 counts, 0 holds and presets |
| cfg_csel | input | 1 | Counter/timer select; 1 disables the clock pin |
| cfg_tclk | input | 1 | Routes the bit-rate tick to tx_tick |
| cfg_rclk | input | 1 | Routes the bit-rate tick to rx_tick |
| cfg_oe | input | 1 | Clock pin output enable |
| cfg_exen | input | 1 | Enables the external falling-edge flag |
| reload_we | input | 1 | Loads reload_val on this edge |
| reload_val | input | 16 | Reload value |
| flag_clr | input | 1 | Clears ext_flag |
| ext_pin | input | 1 | Asynchronous external pin |
| tx_tick | output | 1 | Transmit bit-rate pulse |
| rx_tick | output | 1 | Receive bit-rate pulse |
| clk_out | output | 1 | 50% duty-cycle clock pin |
| ext_flag | output | 1 | Sticky external falling-edge flag |

## Verification
Every timing result is counted in clock edges from the edge that captures the run bit. The clock pin changes at 2×N and 4×N edges, the ticks land at 32×N and 64×N, and the external flag appears on the third edge after the pin changes. The bench drives inputs on falling clock edges and counts rising edges one by one, sampling at each following falling edge. It compares the edge index of each observed change with the figure computed for it. The window runs two edges past the second expected tick, so a late or extra pulse shows up as a miscount.

// File: rtl/t2_pkg.sv
package t2_pkg;
  typedef struct packed {
    logic run;
    logic csel;
    logic tclk;
    logic rclk;
    logic oe;
    logic exen;
  } t2_cfg_t;
endpackage

// File: rtl/t2_count_core.sv
module t2_count_core #(
  parameter int CNT_W     = 16,
  parameter int STATE_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             active,
  input  logic [CNT_W-1:0] reload,
  output logic             ovf
);
  localparam int SW = (STATE_DIV > 1) ? $clog2(STATE_DIV) : 1;
  localparam logic [SW-1:0] ST_LAST = SW'(STATE_DIV - 1);

  logic [SW-1:0]    st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step = active && (st_q == ST_LAST);
  assign ovf  = step && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      cnt_q <= '0;
    end else if (!run) begin
      st_q  <= '0;
      cnt_q <= reload;
    end else if (active) begin
      st_q <= (st_q == ST_LAST) ? '0 : st_q + 1'b1;
      if (step) cnt_q <= (cnt_q == '1) ? reload : cnt_q + 1'b1;
    end
  end

  AST_OVF_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf); // R2
endmodule

// File: rtl/t2_baud_div.sv
module t2_baud_div #(
  parameter int BAUD_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ovf,
  input  logic tclk,
  input  logic rclk,
  output logic tx_tick,
  output logic rx_tick
);
  localparam int DW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(BAUD_DIV - 1);

  logic [DW-1:0] div_q;
  logic          wrap;

  assign wrap = ovf && (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
    end else if (!run) begin
      div_q   <= '0;
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
    end else begin
      if (ovf) div_q <= wrap ? '0 : div_q + 1'b1;
      tx_tick <= wrap && tclk;
      rx_tick <= wrap && rclk;
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |=> !tx_tick); // R4
  AST_TX_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |-> $past(tclk)); // R5
  AST_RX_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |-> $past(rclk)); // R5
endmodule

// File: rtl/t2_clkout.sv
module t2_clkout (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ovf,
  output logic clk_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      clk_out <= 1'b0;
    else if (!en)    clk_out <= 1'b0;
    else if (ovf)    clk_out <= ~clk_out;
  end

  AST_CLKOUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !clk_out); // R3
  AST_CLKOUT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ovf) |=> (clk_out != $past(clk_out))); // R2
endmodule

// File: rtl/t2_ext_edge.sv
module t2_ext_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic exen,
  input  logic clr,
  output logic flag
);
  logic [SYNC-1:0] sq;
  logic            prev_q;
  logic            fall;

  for (genvar g = 0; g < SYNC; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq[g] <= 1'b1;
      else if (g == 0) sq[g] <= pin;
      else sq[g] <= sq[(g > 0) ? g - 1 : 0];
    end
  end

  assign fall = prev_q && !sq[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag   <= 1'b0;
    end else begin
      prev_q <= sq[SYNC-1];
      if (exen && fall) flag <= 1'b1;
      else if (clr)     flag <= 1'b0;
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R7
  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(exen)); // R8
endmodule

// File: rtl/baud_clkout_timer.sv
module baud_clkout_timer #(
  parameter int CNT_W     = 16,
  parameter int STATE_DIV = 2,
  parameter int BAUD_DIV  = 16,
  parameter int SYNC      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_run,
  input  logic             cfg_csel,
  input  logic             cfg_tclk,
  input  logic             cfg_rclk,
  input  logic             cfg_oe,
  input  logic             cfg_exen,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             flag_clr,
  input  logic             ext_pin,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             clk_out,
  output logic             ext_flag
);
  import t2_pkg::*;

  t2_cfg_t          cfg_q;
  logic [CNT_W-1:0] reload_q;
  logic             baud_on;
  logic             clkout_en;
  logic             active;
  logic             ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      reload_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= '{run: cfg_run, csel: cfg_csel, tclk: cfg_tclk,
                             rclk: cfg_rclk, oe: cfg_oe, exen: cfg_exen};
      if (reload_we) reload_q <= reload_val;
    end
  end

  assign baud_on   = cfg_q.tclk || cfg_q.rclk;
  assign clkout_en = cfg_q.oe && !cfg_q.csel;
  assign active    = cfg_q.run && (baud_on || clkout_en);

  t2_count_core #(.CNT_W(CNT_W), .STATE_DIV(STATE_DIV)) core_i (
    .clk(clk), .rst_n(rst_n), .run(cfg_q.run), .active(active),
    .reload(reload_q), .ovf(ovf)
  );

  t2_baud_div #(.BAUD_DIV(BAUD_DIV)) baud_i (
    .clk(clk), .rst_n(rst_n), .run(cfg_q.run), .ovf(ovf),
    .tclk(cfg_q.tclk), .rclk(cfg_q.rclk),
    .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  t2_clkout clkout_i (
    .clk(clk), .rst_n(rst_n), .en(clkout_en), .ovf(ovf), .clk_out(clk_out)
  );

  t2_ext_edge #(.SYNC(SYNC)) edge_i (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .exen(cfg_q.exen),
    .clr(flag_clr), .flag(ext_flag)
  );

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.run && clkout_en) |=> $stable(clk_out)); // R6
  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.run |=> (!tx_tick && !rx_tick)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(baud_on || clkout_en) |=> (!tx_tick && !rx_tick && !clk_out)); // R9
endmodule

// File: tb/baud_clkout_timer_tb_top.sv
module baud_clkout_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_run = 1'b0, cfg_csel = 1'b0, cfg_tclk = 1'b0;
  logic        cfg_rclk = 1'b0, cfg_oe = 1'b0, cfg_exen = 1'b0;
  logic        reload_we = 1'b0;
  logic [15:0] reload_val = '0;
  logic        flag_clr = 1'b0;
  logic        ext_pin = 1'b1;
  logic        tx_tick, rx_tick, clk_out, ext_flag;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_clkout_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_run(cfg_run),
    .cfg_csel(cfg_csel), .cfg_tclk(cfg_tclk), .cfg_rclk(cfg_rclk),
    .cfg_oe(cfg_oe), .cfg_exen(cfg_exen), .reload_we(reload_we),
    .reload_val(reload_val), .flag_clr(flag_clr), .ext_pin(ext_pin),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .clk_out(clk_out), .ext_flag(ext_flag)
  );

  function automatic int exp_co_edge(int n, int i);
    return 2 * n * i;
  endfunction

  function automatic int exp_tick_edge(int n, int i);
    return 32 * n * i;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(bit run, bit csel, bit t, bit r, bit oe, bit exen);
    @(negedge clk);
    cfg_we = 1'b1; cfg_run = run; cfg_csel = csel; cfg_tclk = t;
    cfg_rclk = r; cfg_oe = oe; cfg_exen = exen;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_reload(int n);
    @(negedge clk);
    reload_we = 1'b1; reload_val = 16'(65536 - n);
    @(negedge clk);
    reload_we = 1'b0;
  endtask

  task automatic measure(int n, bit t, bit r, bit co, int inj);
    int lim = 64 * n + 2;
    bit prev = clk_out;
    int c1 = -1, c2 = -1, co_hi = 0;
    int tx1 = -1, tx2 = -1, txn = 0;
    int rx1 = -1, rx2 = -1, rxn = 0;
    for (int k = 1; k <= lim; k++) begin
      if (k == inj) ext_pin = 1'b0;
      @(negedge clk);
      if (clk_out != prev) begin
        if (c1 < 0) c1 = k; else if (c2 < 0) c2 = k;
        prev = clk_out;
      end
      if (clk_out) co_hi++;
      if (tx_tick) begin txn++; if (tx1 < 0) tx1 = k; else if (tx2 < 0) tx2 = k; end
      if (rx_tick) begin rxn++; if (rx1 < 0) rx1 = k; else if (rx2 < 0) rx2 = k; end
    end
    if (co) begin
      chk("R2", "first clk_out change", c1, exp_co_edge(n, 1));
      chk("R2", "second clk_out change", c2, exp_co_edge(n, 2));
    end else begin
      chk(t || r ? "R3" : "R9", "clk_out high samples", co_hi, 0);
    end
    if (t) begin
      chk("R4", "first tx_tick", tx1, exp_tick_edge(n, 1));
      chk("R4", "second tx_tick", tx2, exp_tick_edge(n, 2));
      chk("R4", "tx_tick pulse count", txn, 2);
    end else begin
      chk(co || r ? "R5" : "R9", "tx_tick pulses unselected", txn, 0);
    end
    if (r) begin
      chk("R5", "first rx_tick", rx1, exp_tick_edge(n, 1));
      chk("R5", "second rx_tick", rx2, exp_tick_edge(n, 2));
      chk("R5", "rx_tick pulse count", rxn, 2);
    end else begin
      chk(co || t ? "R5" : "R9", "rx_tick pulses unselected", rxn, 0);
    end
  endtask

  task automatic run_case(int n, bit t, bit r, bit oe, bit csel, bit exen, int inj);
    wr_cfg(1'b0, csel, t, r, oe, exen);
    wr_reload(n);
    wr_cfg(1'b1, csel, t, r, oe, exen);
    measure(n, t, r, oe && !csel, inj);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    bit ref_co;
    int bad;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "tx_tick after reset", int'(tx_tick), 0);
    chk("R1", "rx_tick after reset", int'(rx_tick), 0);
    chk("R1", "clk_out after reset", int'(clk_out), 0);
    chk("R1", "ext_flag after reset", int'(ext_flag), 0);

    // directed corners: smallest period, both uses together, clock disabled paths
    run_case(1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    run_case(3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 0);   // R3 csel blocks clock
    run_case(2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);   // R3 oe off, R5 rx only
    run_case(2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);   // R9 idle
    run_case(4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);   // R2 clock only

    // R6 stop freezes, restart gives a full period
    wr_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    wr_reload(1);
    wr_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    repeat (21) @(negedge clk);
    wr_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    ref_co = clk_out;
    bad = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (clk_out != ref_co || tx_tick) bad++;
    end
    chk("R6", "changes while stopped", bad, 0);
    wr_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    measure(1, 1'b1, 1'b0, 1'b1, 0);

    // R7 external falling edge timing and stickiness
    wr_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    ext_pin = 1'b1;
    repeat (5) @(negedge clk);
    ext_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7", "flag after 2 edges", int'(ext_flag), 0);
    @(negedge clk);
    chk("R7", "flag after 3 edges", int'(ext_flag), 1);
    repeat (10) @(negedge clk);
    chk("R7", "flag held", int'(ext_flag), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R7", "flag after clear", int'(ext_flag), 0);
    // R7 a new edge in the clear cycle wins
    ext_pin = 1'b1;
    repeat (5) @(negedge clk);
    ext_pin = 1'b0;
    repeat (2) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R7", "edge beats clear", int'(ext_flag), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    // R8 rising edge sets nothing
    ext_pin = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8", "flag after rising edge", int'(ext_flag), 0);
    // R8 falling edge with exen clear
    wr_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    ext_pin = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8", "flag with exen off", int'(ext_flag), 0);
    ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    // R8 falling edge during a run causes no reload
    run_case(3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3);
    chk("R8", "flag set during run", int'(ext_flag), 1);
    flag_clr = 1'b1;
    ext_pin = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;

    // constrained random mixes
    for (int i = 0; i < 10; i++) begin
      int n = 1 + int'($urandom_range(5));
      bit t = 1'($urandom_range(1));
      bit r = 1'($urandom_range(1));
      bit oe = 1'($urandom_range(1));
      bit cs = 1'($urandom_range(1));
      run_case(n, t, r, oe, cs, 1'b0, 0);
    end
    finish_run();
  end
endmodule